// File: doc/BRIEF.md
# Debug Watchpoint Match Unit

This unit watches every processor bus access against four programmable address slots. Each slot holds an address and, in a shared control register, a two-bit access-type code, a two-bit length code and two enable bits. When an access falls inside the region of an enabled slot and its kind is one that the slot's type code accepts, the slot's status bit is set. A single-cycle trap pulse is raised in the cycle after the matching access.

Software programs the slot addresses, the control register and the status register through a simple select/write-data/read-data port. Status bits are sticky and are cleared by writing the status register. A task-switch pulse clears the per-slot local enable bits and keeps the global enable bits. The 8-byte length code is honoured only when the wide-mode input is high.

Top module: `wpt_unit`

## Requirements
- R1: After a synchronous active-low reset, all slot addresses, the control register and the status register read zero, and `trap` is low.
- R2: Register select codes are 0 to 3 for the slot addresses, 4 for status (slot bits in the low bits, the rest zero) and 5 for control. Codes 6 and 7 read zero and ignore writes. Control bits 10 to 15 always read zero. All other control bits, including bits 8 and 9, read back as written.
- R3: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is set. A slot with both bits clear never fires. Its 4-bit field sits at control bit 16+4i, with the type code in the low two bits and the length code in the high two bits.
- R4: The access kind is coded 00 fetch, 01 data write, 10 data read and 11 I/O. Type code 00 fires only on a fetch, 01 only on a write, 11 on a read or a write, and 10 only on I/O.
- R5: Length code 00 compares every address bit. Code 01 ignores address bit 0, code 11 ignores bits 1:0, and code 10 ignores bits 2:0. Code 10 fires only while `wide_mode` is 1.
- R6: The status bit of every firing slot is set at the clock edge that samples the access. It stays set until software writes the status register. A write loads the written value, and any slot firing in the same cycle is still ORed in.
- R7: `trap` is high for exactly the one cycle after a cycle in which at least one slot fires, even when several slots fire together.
- R8: A `task_switch` pulse clears every local enable bit and leaves the global enable bits unchanged. When a control write happens in the same cycle, the written value is stored with its local enable bits cleared.
- R9: With `acc_valid` low, no slot fires, whatever the access address and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_sel) |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | 32 | Bus access byte address |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 write, 10 read, 11 I/O |
| wide_mode | input | 1 | Enables the 8-byte length code |
| task_switch | input | 1 | Task-switch pulse |
| trap | output | 1 | One-cycle debug trap pulse |
| status | output | 4 | Sticky per-slot fired bits |

## Verification
The hardest case to reach is a `task_switch` in the same cycle as a control write. The bench asserts both strobes together, then reads the stored value back to see that the written local enables were dropped. A second hard case is several slots firing on one access. Two slots are given the same address and type, and the bench then checks for a single trap pulse with both status bits set. Length matching is checked with addresses just inside and just outside each region, and with the 8-byte code both with and without wide mode.

// File: rtl/wpt_pkg.sv
// Package: shared constants and types for the watchpoint match unit.
// Assumes at most four slots so that the enable bits fit below bit 8.
package wpt_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_READ  = 2'b10,
        KIND_IO    = 2'b11
    } acc_kind_e;

    // Type codes held in the low half of a slot field
    localparam logic [1:0] TYP_EXEC  = 2'b00;
    localparam logic [1:0] TYP_WR    = 2'b01;
    localparam logic [1:0] TYP_IO    = 2'b10;
    localparam logic [1:0] TYP_RW    = 2'b11;

    // Length codes held in the high half of a slot field
    localparam logic [1:0] LEN_B1    = 2'b00;
    localparam logic [1:0] LEN_B2    = 2'b01;
    localparam logic [1:0] LEN_B8    = 2'b10;
    localparam logic [1:0] LEN_B4    = 2'b11;

    localparam int FIELD_BASE = 16;
    localparam int FIELD_W    = 4;
    localparam int EXACT_LO   = 8;
    localparam int EXACT_HI   = 9;
    localparam int RSVD_LO    = 10;
    localparam int RSVD_HI    = 15;

    // Register select codes
    localparam int SEL_W      = 3;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd4;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd5;

endpackage

// File: rtl/wpt_slot_match.sv
// Module: one watch slot comparator.
// Decides, combinationally, whether the current access hits this slot.
// Assumes the field is {len[1:0], type[1:0]} and the slot is already
// known to be enabled through the enabled input.
module wpt_slot_match
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [FIELD_W-1:0] field,
    input  logic              enabled,
    input  logic              wide_mode,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              hit
);

    logic [1:0]        typ;
    logic [1:0]        len;
    logic [ADDR_W-1:0] ign_mask;
    logic              kind_ok;
    logic              len_ok;
    logic              addr_ok;

    assign typ = field[1:0];
    assign len = field[3:2];

    // Purpose: pick the low address bits that the length code ignores
    always_comb begin
        ign_mask = '0;
        len_ok   = 1'b1;
        unique case (len)
            LEN_B1: ign_mask = '0;
            LEN_B2: ign_mask = ADDR_W'(1);
            LEN_B4: ign_mask = ADDR_W'(3);
            LEN_B8: begin
                ign_mask = ADDR_W'(7);
                len_ok   = wide_mode;
            end
            default: ign_mask = '0;
        endcase
    end

    // Purpose: decide whether the access kind is accepted by the type code
    always_comb begin
        unique case (typ)
            TYP_EXEC: kind_ok = (acc_kind == KIND_FETCH);
            TYP_WR:   kind_ok = (acc_kind == KIND_WRITE);
            TYP_RW:   kind_ok = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
            TYP_IO:   kind_ok = (acc_kind == KIND_IO);
            default:  kind_ok = 1'b0;
        endcase
    end

    assign addr_ok = ((acc_addr ^ slot_addr) & ~ign_mask) == '0;
    assign hit     = acc_valid && enabled && len_ok && kind_ok && addr_ok;

endmodule

// File: rtl/wpt_ctrl_reg.sv
// Module: control register with reserved-bit masking and task-switch
// clearing of the local enables. Assumes NSLOT <= 4.
module wpt_ctrl_reg
    import wpt_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int CTRL_W = FIELD_BASE + FIELD_W * NSLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              task_switch,
    output logic [CTRL_W-1:0] ctrl_q
);

    function automatic logic [CTRL_W-1:0] keep_mask_f();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < 2 * NSLOT; i++) m[i] = 1'b1;
        m[EXACT_LO] = 1'b1;
        m[EXACT_HI] = 1'b1;
        for (int i = FIELD_BASE; i < CTRL_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [CTRL_W-1:0] local_mask_f();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSLOT; i++) m[2*i] = 1'b1;
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] KEEP_MASK  = keep_mask_f();
    localparam logic [CTRL_W-1:0] LOCAL_MASK = local_mask_f();

    logic [CTRL_W-1:0] base_val;
    logic [CTRL_W-1:0] next_val;

    // Purpose: merge a software write with the task-switch clear
    always_comb begin
        base_val = wr_en ? (wdata & KEEP_MASK) : ctrl_q;
        next_val = task_switch ? (base_val & ~LOCAL_MASK) : base_val;
    end

    // Purpose: hold the control value
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= next_val;
    end

endmodule

// File: rtl/wpt_status.sv
// Module: sticky status bits and the registered trap pulse.
// Assumes hits are valid combinationally in the access cycle.
module wpt_status #(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NSLOT-1:0] wdata,
    input  logic [NSLOT-1:0] hits,
    output logic [NSLOT-1:0] status_q,
    output logic             trap_q
);

    // Purpose: load written status, OR in this cycle's hits, raise trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            trap_q   <= 1'b0;
        end else begin
            status_q <= (wr_en ? wdata : status_q) | hits;
            trap_q   <= |hits;
        end
    end

endmodule

// File: rtl/wpt_unit.sv
// Module: top of the watchpoint match unit.
// Holds the slot addresses, instantiates one comparator per slot and
// provides the register port. Assumes DATA_W >= ADDR_W and DATA_W >= CTRL_W.
module wpt_unit
    import wpt_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              wide_mode,
    input  logic              task_switch,
    output logic              trap,
    output logic [NSLOT-1:0]  status
);

    localparam int CTRL_W = FIELD_BASE + FIELD_W * NSLOT;

    logic [ADDR_W-1:0] slot_addr_q [NSLOT];
    logic [CTRL_W-1:0] ctrl_q;
    logic [NSLOT-1:0]  hits;
    logic [NSLOT-1:0]  status_q;
    logic              ctrl_we;
    logic              status_we;

    assign ctrl_we   = reg_we && (reg_sel == SEL_CTRL);
    assign status_we = reg_we && (reg_sel == SEL_STATUS);

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            logic addr_we;
            assign addr_we = reg_we && (reg_sel == SEL_W'(g));

            // Purpose: hold this slot's watch address
            always_ff @(posedge clk) begin
                if (!rst_n)       slot_addr_q[g] <= '0;
                else if (addr_we) slot_addr_q[g] <= reg_wdata[ADDR_W-1:0];
            end

            wpt_slot_match #(.ADDR_W(ADDR_W)) u_match (
                .slot_addr (slot_addr_q[g]),
                .field     (ctrl_q[FIELD_BASE + FIELD_W*g +: FIELD_W]),
                .enabled   (|ctrl_q[2*g +: 2]),
                .wide_mode (wide_mode),
                .acc_valid (acc_valid),
                .acc_addr  (acc_addr),
                .acc_kind  (acc_kind),
                .hit       (hits[g])
            );
        end
    endgenerate

    wpt_ctrl_reg #(.NSLOT(NSLOT), .CTRL_W(CTRL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctrl_we),
        .wdata       (reg_wdata[CTRL_W-1:0]),
        .task_switch (task_switch),
        .ctrl_q      (ctrl_q)
    );

    wpt_status #(.NSLOT(NSLOT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (status_we),
        .wdata    (reg_wdata[NSLOT-1:0]),
        .hits     (hits),
        .status_q (status_q),
        .trap_q   (trap)
    );

    assign status = status_q;

    // Purpose: register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL)
            reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        else if (reg_sel == SEL_STATUS)
            reg_rdata = {{(DATA_W-NSLOT){1'b0}}, status_q};
        else
            for (int i = 0; i < NSLOT; i++)
                if (reg_sel == SEL_W'(i))
                    reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, slot_addr_q[i]};
    end

endmodule

// File: rtl/wpt_unit_chk.sv
// Module: assertion checker for wpt_unit, attached by bind.
module wpt_unit_chk #(
    parameter int NSLOT  = 4,
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              task_switch,
    input logic              ctrl_we,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [NSLOT-1:0]  hits,
    input logic              status_we,
    input logic [NSLOT-1:0]  status_q,
    input logic              trap
);

    function automatic logic [CTRL_W-1:0] sel_mask_f(input int off);
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSLOT; i++) m[2*i+off] = 1'b1;
        return m;
    endfunction

    localparam logic [CTRL_W-1:0] LOC_M = sel_mask_f(0);
    localparam logic [CTRL_W-1:0] GLB_M = sel_mask_f(1);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[15:10] == 6'd0); // R2
    AST_TRAP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> trap); // R7
    AST_NO_TRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hits) |=> !trap); // R7
    AST_TRAP_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (status_q != '0)); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_we |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
    AST_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> ((ctrl_q & LOC_M) == '0)); // R8
    AST_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !ctrl_we) |=> ((ctrl_q & GLB_M) == ($past(ctrl_q) & GLB_M))); // R8

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_quiet
            AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_q[2*g +: 2] == 2'b00) |-> !hits[g]); // R3
        end
    endgenerate

endmodule

bind wpt_unit wpt_unit_chk #(.NSLOT(NSLOT), .CTRL_W(CTRL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .task_switch (task_switch),
    .ctrl_we     (ctrl_we),
    .ctrl_q      (ctrl_q),
    .hits        (hits),
    .status_we   (status_we),
    .status_q    (status_q),
    .trap        (trap)
);

// File: tb/wpt_unit_bench.sv
module wpt_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        wide_mode = 1'b0;
    logic        task_switch = 1'b0;
    logic        trap;
    logic [3:0]  status;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpt_unit u_wpt_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .wide_mode(wide_mode),
        .task_switch(task_switch), .trap(trap), .status(status)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] slot;
        logic        wide;
        logic [31:0] addr;
        logic [1:0]  kind;
        logic        exp;
    } vec_t;

    // ctrl: slot 0 local enable (bit 0) plus field {len,type} at bit 16
    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 32'h1000, 1'b0, 32'h1000, 2'b00, 1'b1},  // R4 exec on fetch
        '{32'h0000_0001, 32'h1000, 1'b0, 32'h1000, 2'b01, 1'b0},  // R4 exec ignores write
        '{32'h0000_0001, 32'h1000, 1'b0, 32'h1001, 2'b00, 1'b0},  // R5 1-byte exact
        '{32'h000D_0001, 32'h2000, 1'b0, 32'h2003, 2'b01, 1'b1},  // R5 4-byte write
        '{32'h000D_0001, 32'h2000, 1'b0, 32'h2004, 2'b01, 1'b0},  // R5 4-byte outside
        '{32'h000D_0001, 32'h2000, 1'b0, 32'h2001, 2'b10, 1'b0},  // R4 write-only ignores read
        '{32'h0003_0001, 32'h2000, 1'b0, 32'h2000, 2'b10, 1'b1},  // R4 rw on read
        '{32'h0003_0001, 32'h2000, 1'b0, 32'h2000, 2'b11, 1'b0},  // R4 rw ignores io
        '{32'h0002_0001, 32'h0060, 1'b0, 32'h0060, 2'b11, 1'b1},  // R4 io on io
        '{32'h0005_0001, 32'h3000, 1'b0, 32'h3001, 2'b01, 1'b1},  // R5 2-byte
        '{32'h0005_0001, 32'h3000, 1'b0, 32'h3002, 2'b01, 1'b0},  // R5 2-byte outside
        '{32'h0009_0001, 32'h4000, 1'b1, 32'h4007, 2'b01, 1'b1},  // R5 8-byte wide
        '{32'h0009_0001, 32'h4000, 1'b0, 32'h4007, 2'b01, 1'b0},  // R5 8-byte not wide
        '{32'h0009_0001, 32'h4000, 1'b1, 32'h4008, 2'b01, 1'b0},  // R5 8-byte outside
        '{32'h0000_0002, 32'h1000, 1'b0, 32'h1000, 2'b00, 1'b1},  // R3 global only
        '{32'h0000_0000, 32'h1000, 1'b0, 32'h1000, 2'b00, 1'b0}   // R3 disabled
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trap", {31'd0, trap}, 32'd0);
        check("R1 status", {28'd0, status}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), r);
            check("R1 reg", r, 32'd0);
        end

        // R2 reserved masking and readback
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, r);
        check("R2 ctrl mask", r, 32'hFFFF_03FF);
        wr(3'd2, 32'hDEAD_BEEF);
        rd(3'd2, r);
        check("R2 slot addr", r, 32'hDEAD_BEEF);
        wr(3'd6, 32'h1234_5678);
        rd(3'd6, r);
        check("R2 unused sel", r, 32'd0);
        wr(3'd5, 32'd0);

        // Table walk: R3 R4 R5 matching, R6 status, R7 trap pulse
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd0, VECS[v].slot);
            wr(3'd5, VECS[v].ctrl);
            wide_mode = VECS[v].wide;
            wr(3'd4, 32'd0);
            access(VECS[v].addr, VECS[v].kind);
            check($sformatf("R7 vec%0d trap", v), {31'd0, trap}, {31'd0, VECS[v].exp});
            check($sformatf("R6 vec%0d status", v), {28'd0, status}, {31'd0, VECS[v].exp});
            wr(3'd4, 32'd0);
            check($sformatf("R7 vec%0d pulse end", v), {31'd0, trap}, 32'd0);
        end
        wide_mode = 1'b0;

        // R7 two slots fire together, one pulse; R6 sticky then cleared
        wr(3'd0, 32'h5000);
        wr(3'd2, 32'h5000);
        wr(3'd1, 32'h6000);
        wr(3'd5, 32'h0000_0011);
        access(32'h5000, 2'b00);
        check("R7 multi trap", {31'd0, trap}, 32'd1);
        check("R7 multi status", {28'd0, status}, 32'h5);
        @(negedge clk);
        check("R7 single pulse", {31'd0, trap}, 32'd0);
        repeat (3) @(negedge clk);
        check("R6 sticky", {28'd0, status}, 32'h5);
        wr(3'd4, 32'd0);
        check("R6 cleared", {28'd0, status}, 32'd0);

        // R9 no valid, no fire
        @(negedge clk);
        acc_addr = 32'h5000; acc_kind = 2'b00;
        repeat (2) @(negedge clk);
        check("R9 trap", {31'd0, trap}, 32'd0);
        check("R9 status", {28'd0, status}, 32'd0);

        // R8 task switch clears locals, keeps globals
        wr(3'd5, 32'h0000_00FF);
        @(negedge clk);
        task_switch = 1'b1;
        @(negedge clk);
        task_switch = 1'b0;
        rd(3'd5, r);
        check("R8 locals cleared", r, 32'h0000_00AA);
        access(32'h5000, 2'b00);
        check("R8 global still fires", {28'd0, status}, 32'h5);
        wr(3'd4, 32'd0);

        // R8 write and task switch in same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h0000_030F; task_switch = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; task_switch = 1'b0;
        rd(3'd5, r);
        check("R8 concurrent write", r, 32'h0000_030A);

        // R1 reset clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd5, r);
        check("R1 reset ctrl", r, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule